// File: doc/BRIEF.md
# Bus Read Cycle Controller

This block is a synchronous bus master that performs one processor-style read on an external parallel bus for each accepted request. A request carries an address and a wait-state count. The controller places the address on the bus, drops an active-low read strobe one state later, and captures the data bus when the cycle finishes. The captured word is returned together with a single-cycle completion pulse.

A cycle has three base states: T1, T2 and T3. Slow devices get extra time through Tw states, which are inserted between T2 and T3. There are two sources of Tw states, and they combine. The first is a fixed count of wait states (0 to 7) that is latched with the request. The second is an external wait line that the addressed device holds high for as long as it needs. The wait line is sampled at the end of T2 and at the end of every Tw. The controller moves on to T3 only when the fixed count is used up and the wait line is low at that sample point.

States: `ST_IDLE`, `ST_T1`, `ST_T2`, `ST_TW`, `ST_T3`.

Transitions:
- **accept**: IDLE to T1, when a start request is seen in IDLE.
- **strobe**: T1 to T2.
- **stretch**: T2 or TW to TW, when the remaining fixed count is nonzero or the wait line is high.
- **release**: T2 or TW to T3, when the count is zero and the wait line is low.
- **finish**: T3 to IDLE.

Top module: `rdcyc_master`

## Requirements
- R1: While reset is held and just after it is released, the read strobe is high, busy is low, done is low, the address-drive flag is low and the address bus is zero.
- R2: A start sampled in IDLE is accepted. In the following cycle (T1), the requested address is on the bus, the address-drive flag and busy are high, and the read strobe is still high.
- R3: The read strobe is low in every cycle from T2 through T3 inclusive, and high in every other cycle.
- R4: With a wait-state count of 0 and the wait line low, the cycle is exactly three states. The strobe is low for 2 cycles, and done rises 4 cycles after the edge that accepted the start.
- R5: The number of Tw states is max(N, H). N is the fixed count. H is the number of consecutive sample points, starting at the end of T2, at which the wait line is high.
- R6: data_o takes the bus data present during T3, and done_o is high for exactly one cycle, the cycle after T3.
- R7: After T3, the read strobe returns high, busy falls, the address-drive flag falls and the address bus returns to zero.
- R8: A start request during T1, T2, Tw or T3 is ignored. The address on the bus does not change, and no second cycle follows.
- R9: data_o holds its captured value after the done pulse until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start a read cycle |
| addr_i | input | ADDR_W | Address of the requested read |
| ws_cfg_i | input | WS_W | Fixed wait-state count, latched at accept |
| bus_wait_i | input | 1 | Device wait line, active high |
| bus_data_i | input | DATA_W | Data bus from the device |
| bus_addr_o | output | ADDR_W | Address bus, zero when not driven |
| bus_addr_oe_o | output | 1 | High while the address bus is driven (T1 to T3) |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| busy_o | output | 1 | A cycle is in progress (T1 to T3) |
| done_o | output | 1 | One-cycle pulse marking that data_o is valid |
| data_o | output | DATA_W | Captured read data |

## Verification
Take the clock edge that accepts a start as edge 0. The states and their timing are then fixed:
- T1 occupies cycle 1.
- T2 occupies cycle 2.
- The Tw states occupy cycles 3 to 2+W, where W = max(N, H).
- T3 occupies cycle 3+W.
- Done and the captured data appear in cycle 4+W.

The bench computes W from the stimulus it drives. It steps through every cycle from 1 to 5+W and samples all outputs on the falling edge, comparing each against the value due in that cycle. It drives the wait line on the same falling edge, so each sample point sees exactly the level the bench intended.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4
    } rdc_state_e;

    localparam int unsigned RDC_BASE_STATES = 3;
endpackage

// File: rtl/rdc_wait_ctr.sv
module rdc_wait_ctr #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] cfg_i,
    input  logic          dec_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= cfg_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_q != '0)); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
endmodule

// File: rtl/rdc_fsm.sv
module rdc_fsm
    import rdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ws_zero_i,
    input  logic       bus_wait_i,
    output rdc_state_e state_o,
    output logic       accept_o,
    output logic       ws_dec_o,
    output logic       cap_o,
    output logic       rd_n_o,
    output logic       addr_oe_o,
    output logic       busy_o
);
    rdc_state_e state_q;
    rdc_state_e state_d;
    logic       sample_pt;

    assign sample_pt = (state_q == ST_T2) || (state_q == ST_TW);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_T1;                        // accept
            ST_T1:   state_d = ST_T2;                                     // strobe
            ST_T2,
            ST_TW:   state_d = (!ws_zero_i || bus_wait_i) ? ST_TW : ST_T3; // stretch / release
            ST_T3:   state_d = ST_IDLE;                                   // finish
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        accept_o  = 1'b0;
        ws_dec_o  = 1'b0;
        cap_o     = 1'b0;
        rd_n_o    = 1'b1;
        addr_oe_o = 1'b0;
        busy_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = start_i;
            ST_T1: begin
                addr_oe_o = 1'b1;
                busy_o    = 1'b1;
            end
            ST_T2, ST_TW: begin
                addr_oe_o = 1'b1;
                busy_o    = 1'b1;
                rd_n_o    = 1'b0;
                ws_dec_o  = sample_pt && !ws_zero_i;
            end
            ST_T3: begin
                addr_oe_o = 1'b1;
                busy_o    = 1'b1;
                rd_n_o    = 1'b0;
                cap_o     = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_ACCEPT_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_T1)); // R2

    AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T1) |=> (state_q == ST_T2)); // R4

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pt && bus_wait_i) |=> (state_q == ST_TW)); // R5

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pt && ws_zero_i && !bus_wait_i) |=> (state_q == ST_T3)); // R5

    AST_T3_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T3) |=> (state_q == ST_IDLE)); // R7

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != ST_T3) |=> busy_o && (state_q != ST_T1)); // R8
endmodule

// File: rtl/rdc_datapath.sv
module rdc_datapath #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [AW-1:0] addr_i,
    input  logic          addr_oe_i,
    input  logic          cap_i,
    input  logic [DW-1:0] bus_data_i,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] data_o,
    output logic          done_o
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept_i) begin
            addr_q <= addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= cap_i;
            if (cap_i) begin
                data_q <= bus_data_i;
            end
        end
    end

    assign bus_addr_o = addr_oe_i ? addr_q : '0;
    assign data_o     = data_q;
    assign done_o     = done_q;

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_i) |-> $stable(data_q)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
endmodule

// File: rtl/rdcyc_master.sv
module rdcyc_master #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WS_W-1:0]   ws_cfg_i,
    input  logic              bus_wait_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_addr_oe_o,
    output logic              bus_rd_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);
    import rdc_pkg::*;

    rdc_state_e state;
    logic       accept;
    logic       ws_dec;
    logic       ws_zero;
    logic       cap;

    rdc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ws_zero_i (ws_zero),
        .bus_wait_i(bus_wait_i),
        .state_o   (state),
        .accept_o  (accept),
        .ws_dec_o  (ws_dec),
        .cap_o     (cap),
        .rd_n_o    (bus_rd_n_o),
        .addr_oe_o (bus_addr_oe_o),
        .busy_o    (busy_o)
    );

    rdc_wait_ctr #(.CW(WS_W)) u_wait_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .cfg_i  (ws_cfg_i),
        .dec_i  (ws_dec),
        .zero_o (ws_zero)
    );

    rdc_datapath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .addr_i    (addr_i),
        .addr_oe_i (bus_addr_oe_o),
        .cap_i     (cap),
        .bus_data_i(bus_data_i),
        .bus_addr_o(bus_addr_o),
        .data_o    (data_o),
        .done_o    (done_o)
    );

    AST_STROBE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n_o) |-> $past(bus_addr_oe_o)); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(bus_addr_o)); // R8

    AST_DONE_AFTER_T3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state) == ST_T3) && !busy_o && bus_rd_n_o); // R7
endmodule

// File: tb/rdcyc_master_bench.sv
`timescale 1ns/1ps
module rdcyc_master_bench;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [WW-1:0] ws_cfg_i = '0;
    logic          bus_wait_i = 1'b0;
    logic [DW-1:0] bus_data_i;
    logic [AW-1:0] bus_addr_o;
    logic          bus_addr_oe_o, bus_rd_n_o, busy_o, done_o;
    logic [DW-1:0] data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    assign bus_data_i = bus_rd_n_o ? '0 : mem_word(bus_addr_o);

    rdcyc_master #(.ADDR_W(AW), .DATA_W(DW), .WS_W(WW)) u_rdcyc_master (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .ws_cfg_i(ws_cfg_i), .bus_wait_i(bus_wait_i), .bus_data_i(bus_data_i),
        .bus_addr_o(bus_addr_o), .bus_addr_oe_o(bus_addr_oe_o),
        .bus_rd_n_o(bus_rd_n_o), .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // one read: n fixed waits, h wait-line samples high, ign = cycle index of a stray start (0 = none)
    task automatic run_read(input logic [AW-1:0] a, input int n, input int h, input int ign);
        int w;
        logic [DW-1:0] exp_d;
        w = (n > h) ? n : h;
        exp_d = mem_word(a);
        @(negedge clk);
        addr_i = a; ws_cfg_i = WW'(n); start_i = 1'b1; bus_wait_i = 1'b0;
        @(posedge clk);
        for (int i = 1; i <= 5 + w; i++) begin
            @(negedge clk);
            start_i = (i == ign);
            addr_i = ~a;
            bus_wait_i = (i >= 2) && (i - 2 < h);
            chk("R2 busy", 32'(busy_o), 32'((i >= 1) && (i <= 3 + w)));
            chk("R3 strobe", 32'(bus_rd_n_o), 32'(!((i >= 2) && (i <= 3 + w))));
            chk("R7 addr", 32'(bus_addr_o), (i <= 3 + w) ? 32'(a) : 32'd0);
            chk("R7 addr_oe", 32'(bus_addr_oe_o), 32'(i <= 3 + w));
            chk("R6 done", 32'(done_o), 32'(i == 4 + w));
            if (i == 4 + w) chk("R6 data", 32'(data_o), 32'(exp_d));
            if (i == 5 + w) chk("R9 hold", 32'(data_o), 32'(exp_d));
            if (n == 0 && h == 0 && i == 4) chk("R4 base", 32'(done_o), 32'd1);
            if (i == 2 + w) chk("R5 tw", 32'(bus_rd_n_o), 32'd0);
            if (ign != 0 && i == 5 + w) chk("R8 ignore", 32'(busy_o), 32'd0);
        end
        start_i = 1'b0;
        bus_wait_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        chk("R1 rd_n", 32'(bus_rd_n_o), 32'd1);
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 addr", 32'(bus_addr_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", 32'(busy_o), 32'd0);
        // directed corners
        run_read(16'h1234, 0, 0, 0);  // R4
        run_read(16'h0001, 2, 0, 0);  // R5 fixed only
        run_read(16'hBEEF, 0, 3, 0);  // R5 wait line only
        run_read(16'h8000, 4, 2, 0);  // R5 count dominates
        run_read(16'h00FF, 1, 5, 0);  // R5 wait dominates
        run_read(16'hCAFE, 7, 0, 2);  // R8 stray start in T2
        run_read(16'h7777, 0, 0, 1);  // R8 stray start in T1
        run_read(16'h4242, 0, 0, 3);  // R8 stray start in T3
        for (int k = 0; k < 60; k++) begin
            int n, h, w, ign;
            n = int'($urandom % 8);
            h = int'($urandom % 10);
            w = (n > h) ? n : h;
            ign = ($urandom % 2) ? int'(1 + $urandom % (3 + w)) : 0;
            run_read(AW'($urandom), n, h, ign);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule